// File: doc/BRIEF.md
# Serial-Programmed Clock Fanout Enable Controller

This block gates one reference clock onto ten outputs. Each output has its own enable bit. A write-only two-wire serial slave loads these bits. The slave samples the bus lines into a fast system clock and finds START and STOP conditions. It acknowledges writes to its own 7-bit address and counts the data bytes of each transfer.

The first two data bytes after the address are acknowledged and then thrown away. The third byte carries the enables for outputs 0 to 7. The fourth byte carries the enables for outputs 8 and 9. All later bytes are acknowledged and discarded.

A global output-enable pin sits above all per-output enables and is meant for test. After reset every enable is set, so all outputs run as soon as the global pin is high.

Top module: `fanout_gate_ctrl`

## Requirements
- R1: After reset all ten enable bits are 1, `sda_pull_o` is 0 (bus released), and each output follows `ref_clk_i` while `oe_i` is 1.
- R2: After a START, an address byte whose upper seven bits equal `SLV_ADDR` and whose last bit (R/W) is 0 is acknowledged: `sda_pull_o` is 1 while SCL is high in the ninth clock of that byte.
- R3: An address byte that does not match, or that has R/W = 1, is not acknowledged. Every byte after it until the next START or STOP is neither acknowledged nor stored.
- R4: In a matched write, every data byte is acknowledged on its ninth SCL clock, including the two discarded bytes.
- R5: Data bytes 0 and 1 after the address do not change any enable bit.
- R6: Bit i of data byte 2 (bit 0 is the last bit sent) becomes the enable of output i, for i = 0 to 7.
- R7: Bits 1:0 of data byte 3 become the enables of outputs 9:8. Bits 7:2 of that byte, and all of data byte 4 and later bytes, are ignored.
- R8: A STOP or a repeated START resets the data-byte count to 0. Enable bytes that a shorter transfer did not reach keep their values.
- R9: Output i equals `ref_clk_i` AND enable i AND `oe_i`. A disabled output is held low.
- R10: While `oe_i` is 0, all outputs are 0 whatever the enable bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. Must be at least 10 times the serial bit rate. |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized inside the block. |
| scl_i | input | 1 | Serial clock line level. |
| sda_i | input | 1 | Serial data line level. |
| sda_pull_o | output | 1 | 1 = pull the data line low (acknowledge). |
| ref_clk_i | input | 1 | Reference clock that is fanned out. |
| oe_i | input | 1 | Global output enable, active high. |
| clk_out_o | output | 10 | Gated clock outputs. |

## Verification
The hardest states to reach are the transfers that are cut short: a repeated START or a STOP that arrives after some bytes have been stored but before the upper enable byte. A second hard case is a rejected address, where the slave must ignore every byte until the next START or STOP. The bench drives random transfers with 0 to 6 data bytes each. It picks at random between a matching write, a wrong address and a read request, and ends each transfer with either a STOP or a direct repeated START. As a result, partial writes and transfers that run past the fourth byte both occur often. Directed transfers then cover exactly three bytes, exactly two bytes, a read request with trailing data, and the global enable held low.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/fgc_bus_sync.sv
module fgc_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh_q, scl_sh_d;
  logic [STAGES-1:0] sda_sh_q, sda_sh_d;
  logic scl_prev_q, sda_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      assign scl_sh_d = scl_i;
      assign sda_sh_d = sda_i;
    end else begin : g_many
      assign scl_sh_d = {scl_sh_q[STAGES-2:0], scl_i};
      assign sda_sh_d = {sda_sh_q[STAGES-2:0], sda_i};
    end
  endgenerate

  assign scl_o = scl_sh_q[STAGES-1];
  assign sda_o = sda_sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q   <= '1;
      sda_sh_q   <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sh_q   <= scl_sh_d;
      sda_sh_q   <= sda_sh_d;
      scl_prev_q <= scl_o;
      sda_prev_q <= sda_o;
    end
  end

  assign scl_rise_o = scl_o & ~scl_prev_q;
  assign scl_fall_o = ~scl_o & scl_prev_q;
  assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
  assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/fgc_rx_fsm.sv
module fgc_rx_fsm
  import fgc_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR   = 7'h52,
  parameter int         SKIP_BYTES = 2,
  parameter int         N_BYTES    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  output logic               sda_pull_o,
  output logic [N_BYTES-1:0] wr_stb_o,
  output logic [7:0]         wr_byte_o,
  output rx_state_e          state_o
);
  localparam int CNT_MAX = SKIP_BYTES + N_BYTES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  rx_state_e        state_q, state_d;
  logic [3:0]       bit_q, bit_d;
  logic             ackph_q, ackph_d;
  logic             ack_q, ack_d;
  logic [7:0]       sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign upd = start_det | stop_det | scl_rise | scl_fall;

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    ackph_d  = ackph_q;
    ack_d    = ack_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    wr_stb_o = '0;
    if (start_det || stop_det) begin
      state_d = start_det ? RX_ADDR : RX_IDLE;
      bit_d   = '0;
      ackph_d = 1'b0;
      ack_d   = 1'b0;
      cnt_d   = '0;
    end else if (state_q == RX_ADDR || state_q == RX_DATA) begin
      if (scl_rise && bit_q != 4'd8) begin
        sh_d  = {sh_q[6:0], sda};
        bit_d = bit_q + 4'd1;
      end else if (scl_fall && bit_q == 4'd8 && !ackph_q) begin
        ackph_d = 1'b1;
        if (state_q == RX_ADDR) begin
          if (sh_q == {SLV_ADDR, 1'b0}) begin
            ack_d = 1'b1;
          end else begin
            state_d = RX_SKIP;
            ackph_d = 1'b0;
          end
        end else begin
          ack_d = 1'b1;
          for (int b = 0; b < N_BYTES; b++) begin
            if (cnt_q == CNT_W'(SKIP_BYTES + b)) wr_stb_o[b] = 1'b1;
          end
          if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
        end
      end else if (scl_fall && ackph_q) begin
        ack_d   = 1'b0;
        ackph_d = 1'b0;
        bit_d   = '0;
        if (state_q == RX_ADDR) state_d = RX_DATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      bit_q   <= '0;
      ackph_q <= 1'b0;
      ack_q   <= 1'b0;
      sh_q    <= '0;
      cnt_q   <= '0;
    end else if (upd) begin
      state_q <= state_d;
      bit_q   <= bit_d;
      ackph_q <= ackph_d;
      ack_q   <= ack_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
    end
  end

  assign sda_pull_o = ack_q;
  assign wr_byte_o  = sh_q;
  assign state_o    = state_q;
endmodule

// File: rtl/fgc_gate.sv
module fgc_gate #(
  parameter int N_OUT   = 10,
  parameter int N_BYTES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_BYTES-1:0] wr_stb,
  input  logic [7:0]         wr_byte,
  input  logic               ref_clk,
  input  logic               oe,
  output logic [N_OUT-1:0]   en_o,
  output logic [N_OUT-1:0]   clk_out_o
);
  logic [N_OUT-1:0] en_q, en_d, load;

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_lane
      assign load[i]      = wr_stb[i / 8];
      assign en_d[i]      = load[i] ? wr_byte[i % 8] : en_q[i];
      assign clk_out_o[i] = ref_clk & oe & en_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '1;
    else if (|load)   en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/fanout_gate_ctrl.sv
module fanout_gate_ctrl #(
  parameter logic [6:0] SLV_ADDR    = 7'h52,
  parameter int         N_OUT       = 10,
  parameter int         SKIP_BYTES  = 2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic             ref_clk_i,
  input  logic             oe_i,
  output logic [N_OUT-1:0] clk_out_o
);
  localparam int N_BYTES = (N_OUT + 7) / 8;

  logic rst_meta_q, rst_sync_n;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [N_BYTES-1:0] wr_stb;
  logic [7:0]         wr_byte;
  logic [N_OUT-1:0]   en;
  fgc_pkg::rx_state_e rx_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  fgc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  fgc_rx_fsm #(.SLV_ADDR(SLV_ADDR), .SKIP_BYTES(SKIP_BYTES), .N_BYTES(N_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_sync_n), .sda(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_pull_o(sda_pull_o), .wr_stb_o(wr_stb), .wr_byte_o(wr_byte),
    .state_o(rx_state)
  );

  fgc_gate #(.N_OUT(N_OUT), .N_BYTES(N_BYTES)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .ref_clk(ref_clk_i), .oe(oe_i), .en_o(en), .clk_out_o(clk_out_o)
  );
endmodule

// File: rtl/fgc_chk.sv
module fgc_chk
  import fgc_pkg::*;
#(
  parameter int N_OUT   = 10,
  parameter int N_BYTES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_s,
  input logic               sda_pull,
  input logic [N_BYTES-1:0] wr_stb,
  input logic [N_OUT-1:0]   en,
  input logic               oe,
  input logic [N_OUT-1:0]   clk_out,
  input rx_state_e          state
);
  AST_ONE_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb)); // R7
  AST_EN_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (en != $past(en)) |-> $past(|wr_stb)); // R5
  AST_ACK_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_pull)); // R2
  AST_NO_ACK_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_SKIP || state == RX_IDLE) |-> !sda_pull); // R3
  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out & ~en) == '0); // R9
  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (clk_out == '0)); // R10
endmodule

bind fanout_gate_ctrl fgc_chk #(.N_OUT(N_OUT), .N_BYTES(N_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .scl_s(scl_s), .sda_pull(sda_pull_o),
  .wr_stb(wr_stb), .en(en), .oe(oe_i), .clk_out(clk_out_o), .state(rx_state)
);

// File: tb/fanout_gate_ctrl_tb.sv
module fanout_gate_ctrl_tb;
  localparam logic [6:0] ADDR = 7'h52;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, ref_clk = 1'b0, oe = 1'b1;
  logic sda_pull;
  logic [9:0] clk_out;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, errors = 0;
  logic [9:0] exp_en;

  always #10 clk = ~clk;

  fanout_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .ref_clk_i(ref_clk), .oe_i(oe), .clk_out_o(clk_out)
  );

  function automatic logic [9:0] model_out(logic [9:0] e, logic o, logic r);
    return (o && r) ? e : 10'd0;
  endfunction

  task automatic wait_q(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(string tag);
    for (int k = 0; k < 2; k++) begin
      ref_clk = (k == 1);
      wait_q(2);
      check(clk_out == model_out(exp_en, oe, ref_clk), tag, clk_out, model_out(exp_en, oe, ref_clk));
    end
    ref_clk = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(Q);
    scl = 1'b1;   wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl = 1'b0;   wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl = 1'b1;   wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic bus_byte(logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl = 1'b1;   wait_q(2 * Q);
      scl = 1'b0;
    end
    sda_m = 1'b1; wait_q(Q);
    scl = 1'b1;   wait_q(Q);
    acked = ~sda_line;
    wait_q(Q);
    scl = 1'b0;
  endtask

  task automatic send_xfer(logic [7:0] addr_b, logic [7:0] data [], bit matched,
                           bit do_stop, string atag);
    logic a;
    bus_start();
    bus_byte(addr_b, a);
    check(a == matched, atag, a, matched);
    foreach (data[j]) begin
      bus_byte(data[j], a);
      check(a == matched, matched ? "R4 data ack" : "R3 no ack after reject", a, matched);
      if (matched && j == 2) exp_en[7:0] = data[j];
      if (matched && j == 3) exp_en[9:8] = data[j][1:0];
    end
    if (do_stop) bus_stop();
    wait_q(8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d [];
    void'($urandom(32'h5eed1234));
    exp_en = '1;
    wait_q(4);
    rst_n = 1'b1;
    wait_q(6);
    check(sda_pull == 1'b0, "R1 bus released", sda_pull, 0);
    check_outs("R1 reset all enabled");

    d = '{8'hFF, 8'hFF, 8'hA5};
    send_xfer({ADDR, 1'b0}, d, 1'b1, 1'b1, "R2 address ack");
    check_outs("R6 low byte / R8 upper kept");

    d = '{8'h00, 8'h00, 8'h3C, 8'hFE, 8'h00, 8'hFF};
    send_xfer({ADDR, 1'b0}, d, 1'b1, 1'b1, "R2 address ack");
    check_outs("R7 upper bits and extra bytes");

    d = '{8'h00, 8'h00};
    send_xfer({ADDR, 1'b0}, d, 1'b1, 1'b1, "R2 address ack");
    check_outs("R5 skipped bytes ignored");

    d = '{8'h00, 8'h00, 8'h00, 8'h00};
    send_xfer({ADDR, 1'b1}, d, 1'b0, 1'b1, "R3 read rejected");
    check_outs("R3 read transfer ignored");

    d = '{8'h11, 8'h22, 8'hF0};
    send_xfer({ADDR, 1'b0}, d, 1'b1, 1'b0, "R2 address ack");
    d = '{8'h00, 8'h00, 8'h0F};
    send_xfer({ADDR, 1'b0}, d, 1'b1, 1'b1, "R8 repeated start restarts count");
    check_outs("R8 after repeated start");

    oe = 1'b0;
    check_outs("R10 global off");
    oe = 1'b1;

    for (int t = 0; t < 40; t++) begin
      int kind, n;
      logic [7:0] ab;
      kind = $urandom % 4;
      n = $urandom % 7;
      if (kind < 2)       ab = {ADDR, 1'b0};
      else if (kind == 2) ab = {ADDR ^ 7'(1 + $urandom % 127), 1'b0};
      else                ab = {ADDR, 1'b1};
      d = new[n];
      foreach (d[j]) d[j] = 8'($urandom);
      send_xfer(ab, d, kind < 2, ($urandom % 2) == 1,
                kind < 2 ? "R2 random ack" : "R3 random reject");
      oe = ($urandom % 4) != 0;
      check_outs("R9 random gating");
      oe = 1'b1;
    end
    bus_stop();
    wait_q(8);
    check_outs("R8 final state");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule